// File: doc/BRIEF.md
# Branch Target Predictor Table

This block sits beside the fetch stage and answers, in the same cycle a fetch address goes out to instruction memory, two questions: is the instruction at this address a branch that has been seen before, and if so, where does it go. It is a direct-mapped table. The low bits of the fetch address select one entry. The remaining upper bits are compared against a stored tag. On a hit the block steers the next fetch address to the stored destination. On a miss the next fetch address is the sequential one.

Branches are resolved further down the pipeline, which always computes the real destination. The resolving stage sends four things back through the update port: the branch address, the computed destination, and the hit flag and target that were predicted for it at fetch. The block writes the computed destination into the table on every resolution. In that same cycle it raises a flush and a redirect address when the prediction was absent or wrong, so the pipeline can squash the younger instructions it fetched speculatively.

Top module: `btb_predictor`

## Requirements
- R1: After a synchronous reset every entry is empty, so no fetch address hits until an update has written its entry.
- R2: The entry index is fetch address bits [3:0] and the tag is bits [15:4]. A lookup hits only when the indexed entry is valid and its stored tag equals the fetch tag, so an address that shares an index but has a different tag misses.
- R3: On a hit, pred_target equals the destination last written for that address, and next_pc equals pred_target.
- R4: On a miss, pred_hit is 0 and next_pc is fetch_pc + 1, modulo 2^16 (0xFFFF is followed by 0x0000).
- R5: Every update overwrites the indexed entry with the new tag and the new destination, whether or not the old contents matched.
- R6: An update takes effect from the next cycle onward. A lookup of the same entry in the update cycle returns the contents from before the update.
- R7: In the cycle of an update, flush is 1 when the recorded prediction was a miss or its target differs from the computed destination. redirect_pc carries the computed destination. Flush is never 1 without an update.
- R8: An update whose recorded prediction was a hit with the correct target gives flush 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | 16 | Address being fetched this cycle |
| pred_hit | output | 1 | Fetch address is a known branch |
| pred_target | output | 16 | Predicted destination (valid when pred_hit) |
| next_pc | output | 16 | Next fetch address |
| upd_valid | input | 1 | A branch resolves this cycle |
| upd_pc | input | 16 | Address of the resolving branch |
| upd_target | input | 16 | Computed destination |
| upd_was_hit | input | 1 | Hit flag that was predicted for this branch at fetch |
| upd_pred_target | input | 16 | Target that was predicted for this branch at fetch |
| flush | output | 1 | Squash younger instructions and redirect |
| redirect_pc | output | 16 | Address to refetch from when flush is 1 |

## Verification
The hardest case to reach is an update and a lookup that land on the same entry in the same cycle, especially when the update also replaces the tag of an aliasing address. Random addresses spread across sixteen entries almost never line up like this. The stimulus therefore draws tags from a small pool of four values, so that aliasing and re-use happen often. Directed steps also issue a lookup and an update to one address together, check that the old contents come back, and then check the new contents in the following cycle.

// File: rtl/btb_pkg.sv
package btb_pkg;

    localparam int PC_W_DEF  = 16;
    localparam int IDX_W_DEF = 4;

    // Reason for a redirect at resolution time
    typedef enum logic [1:0] {
        REDIR_NONE  = 2'd0,
        REDIR_COLD  = 2'd1,   // branch was not in the table at fetch
        REDIR_WRONG = 2'd2    // table held a stale destination
    } redir_cause_e;

    function automatic logic [PC_W_DEF-1:0] seq_next(input logic [PC_W_DEF-1:0] pc);
        return pc + {{(PC_W_DEF-1){1'b0}}, 1'b1};
    endfunction

endpackage

// File: rtl/btb_table.sv
module btb_table #(
    parameter int PC_W  = btb_pkg::PC_W_DEF,
    parameter int IDX_W = btb_pkg::IDX_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] rd_pc,
    output logic            rd_hit,
    output logic [PC_W-1:0] rd_target,
    input  logic            wr_en,
    input  logic [PC_W-1:0] wr_pc,
    input  logic [PC_W-1:0] wr_target
);
    localparam int TAG_W = PC_W - IDX_W;
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [PC_W-1:0]  target;
    } entry_t;

    entry_t entries [DEPTH];

    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic [TAG_W-1:0] rd_tag, wr_tag;

    assign rd_idx = rd_pc[IDX_W-1:0];
    assign rd_tag = rd_pc[PC_W-1:IDX_W];
    assign wr_idx = wr_pc[IDX_W-1:0];
    assign wr_tag = wr_pc[PC_W-1:IDX_W];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                entries[e].valid  <= 1'b0;
                entries[e].tag    <= '0;
                entries[e].target <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                entries[e].valid  <= 1'b1;
                entries[e].tag    <= wr_tag;
                entries[e].target <= wr_target;
            end
        end
    end

    entry_t sel;
    always_comb begin
        sel       = entries[rd_idx];
        rd_hit    = sel.valid && (sel.tag == rd_tag);
        rd_target = sel.target;
    end

    // R1: the first cycle after reset sees an empty table
    p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rd_hit);

    // R5, R6: a write is visible on the following cycle
    p_write_visible_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((rd_pc != $past(wr_pc)) ||
                   (rd_hit && (rd_target == $past(wr_target)))));

endmodule

// File: rtl/btb_check.sv
module btb_check #(
    parameter int PC_W = btb_pkg::PC_W_DEF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  upd_valid,
    input  logic                  upd_was_hit,
    input  logic [PC_W-1:0]       upd_pred_target,
    input  logic [PC_W-1:0]       upd_target,
    output btb_pkg::redir_cause_e cause,
    output logic                  flush
);
    import btb_pkg::*;

    always_comb begin
        cause = REDIR_NONE;
        if (upd_valid) begin
            if (!upd_was_hit)
                cause = REDIR_COLD;
            else if (upd_pred_target != upd_target)
                cause = REDIR_WRONG;
        end
    end

    assign flush = (cause != REDIR_NONE);

    // R7: no squash without a resolving branch
    p_flush_needs_update_r7: assert property (@(posedge clk) disable iff (rst)
        flush |-> upd_valid);

    // R8: a correct prediction never squashes
    p_no_false_flush_r8: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_was_hit && (upd_pred_target == upd_target)) |-> !flush);

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor #(
    parameter int PC_W  = btb_pkg::PC_W_DEF,
    parameter int IDX_W = btb_pkg::IDX_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_hit,
    output logic [PC_W-1:0] pred_target,
    output logic [PC_W-1:0] next_pc,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic [PC_W-1:0] upd_target,
    input  logic            upd_was_hit,
    input  logic [PC_W-1:0] upd_pred_target,
    output logic            flush,
    output logic [PC_W-1:0] redirect_pc
);
    import btb_pkg::*;

    redir_cause_e cause;
    logic [PC_W-1:0] seq_pc;

    btb_table #(.PC_W(PC_W), .IDX_W(IDX_W)) u_table (
        .clk       (clk),
        .rst       (rst),
        .rd_pc     (fetch_pc),
        .rd_hit    (pred_hit),
        .rd_target (pred_target),
        .wr_en     (upd_valid),
        .wr_pc     (upd_pc),
        .wr_target (upd_target)
    );

    btb_check #(.PC_W(PC_W)) u_check (
        .clk             (clk),
        .rst             (rst),
        .upd_valid       (upd_valid),
        .upd_was_hit     (upd_was_hit),
        .upd_pred_target (upd_pred_target),
        .upd_target      (upd_target),
        .cause           (cause),
        .flush           (flush)
    );

    assign seq_pc      = fetch_pc + PC_W'(1);
    assign next_pc     = pred_hit ? pred_target : seq_pc;
    assign redirect_pc = upd_target;

    // R3: a hit steers fetch to the stored destination
    p_hit_steers_r3: assert property (@(posedge clk) disable iff (rst)
        pred_hit |-> (next_pc == pred_target));

    // R4: a miss falls through to the sequential address
    p_miss_sequential_r4: assert property (@(posedge clk) disable iff (rst)
        !pred_hit |-> (next_pc == PC_W'(fetch_pc + PC_W'(1))));

    // R7: a cold branch always redirects
    p_cold_redirects_r7: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_was_hit) |-> (flush && (cause == REDIR_COLD)));

endmodule

// File: tb/btb_predictor_bench.sv
`timescale 1ns/1ps
module btb_predictor_bench;
    localparam int PC_W  = 16;
    localparam int IDX_W = 4;
    localparam int TAG_W = PC_W - IDX_W;
    localparam int DEPTH = 1 << IDX_W;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [PC_W-1:0] fetch_pc = '0;
    logic            pred_hit;
    logic [PC_W-1:0] pred_target, next_pc, redirect_pc;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0, upd_target = '0, upd_pred_target = '0;
    logic            upd_was_hit = 1'b0;
    logic            flush;

    int checks = 0;
    int failures = 0;

    logic             m_v   [DEPTH];
    logic [TAG_W-1:0] m_tag [DEPTH];
    logic [PC_W-1:0]  m_tgt [DEPTH];

    always #2 clk = ~clk;

    btb_predictor u_btb_predictor (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .pred_hit(pred_hit),
        .pred_target(pred_target), .next_pc(next_pc), .upd_valid(upd_valid),
        .upd_pc(upd_pc), .upd_target(upd_target), .upd_was_hit(upd_was_hit),
        .upd_pred_target(upd_pred_target), .flush(flush), .redirect_pc(redirect_pc)
    );

    function automatic logic m_hit(input logic [PC_W-1:0] pc);
        return m_v[pc[IDX_W-1:0]] && (m_tag[pc[IDX_W-1:0]] == pc[PC_W-1:IDX_W]);
    endfunction

    function automatic logic [PC_W-1:0] m_next(input logic [PC_W-1:0] pc);
        return m_hit(pc) ? m_tgt[pc[IDX_W-1:0]] : PC_W'(pc + 1);
    endfunction

    task automatic model_clear();
        for (int i = 0; i < DEPTH; i++) begin
            m_v[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0;
        end
    endtask

    task automatic chk(input logic ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
        end
    endtask

    // one cycle: drive at negedge, check 1 ns later, model the write at posedge
    task automatic step(input logic [PC_W-1:0] pc, input logic uv, input logic [PC_W-1:0] upc,
                        input logic [PC_W-1:0] utgt, input logic uh, input logic [PC_W-1:0] upt,
                        input string rq);
        logic eh, ef;
        @(negedge clk);
        fetch_pc = pc; upd_valid = uv; upd_pc = upc; upd_target = utgt;
        upd_was_hit = uh; upd_pred_target = upt;
        #1;
        eh = m_hit(pc);
        chk(pred_hit == eh, rq, 32'(pred_hit), 32'(eh));
        if (eh) chk(pred_target == m_tgt[pc[IDX_W-1:0]], "R3 target", 32'(pred_target), 32'(m_tgt[pc[IDX_W-1:0]]));
        chk(next_pc == m_next(pc), eh ? "R3 next_pc" : "R4 next_pc", 32'(next_pc), 32'(m_next(pc)));
        ef = uv && (!uh || (upt != utgt));
        chk(flush == ef, ef ? "R7 flush" : "R8 flush", 32'(flush), 32'(ef));
        if (ef) chk(redirect_pc == utgt, "R7 redirect", 32'(redirect_pc), 32'(utgt));
        @(posedge clk);
        if (uv) begin
            m_v[upc[IDX_W-1:0]]   = 1'b1;
            m_tag[upc[IDX_W-1:0]] = upc[PC_W-1:IDX_W];
            m_tgt[upc[IDX_W-1:0]] = utgt;
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; upd_valid = 1'b0;
        repeat (3) @(posedge clk);
        model_clear();
        @(negedge clk); rst = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd7715));
        model_clear();
        do_reset();
        // R1: empty after reset
        step(16'h0003, 0, 0, 0, 0, 0, "R1 empty");
        step(16'h1235, 0, 0, 0, 0, 0, "R1 empty");
        // R4: wrap on miss
        step(16'hFFFF, 0, 0, 0, 0, 0, "R4 wrap");
        // R7 cold branch; R6 same-cycle lookup returns old (miss)
        step(16'h0125, 1, 16'h0125, 16'h0800, 0, 0, "R6 old contents");
        step(16'h0125, 0, 0, 0, 0, 0, "R6 visible next cycle");
        // R2 alias: same index, different tag
        step(16'h0135, 0, 0, 0, 0, 0, "R2 alias miss");
        // R8 correct prediction; R7 wrong target
        step(16'h0125, 1, 16'h0125, 16'h0800, 1, 16'h0800, "R3 hit");
        step(16'h0125, 1, 16'h0125, 16'h0900, 1, 16'h0800, "R6 old target");
        step(16'h0125, 0, 0, 0, 0, 0, "R5 overwrite target");
        // R5 alias overwrite replaces tag
        step(16'h0125, 1, 16'h0135, 16'h0A00, 0, 0, "R6 old tag");
        step(16'h0125, 0, 0, 0, 0, 0, "R5 old tag evicted");
        step(16'h0135, 0, 0, 0, 0, 0, "R5 new tag hits");
        // R1 mid-run reset forgets entries
        do_reset();
        step(16'h0135, 0, 0, 0, 0, 0, "R1 cleared");
        // random traffic with a small tag pool
        for (int n = 0; n < 3000; n++) begin
            logic [PC_W-1:0] pc, upc, utgt, upt;
            logic uv, uh;
            pc   = {PC_W'($urandom_range(0, 3)) << IDX_W} | PC_W'($urandom_range(0, DEPTH-1));
            upc  = ($urandom_range(0, 3) == 0) ? pc :
                   ({PC_W'($urandom_range(0, 3)) << IDX_W} | PC_W'($urandom_range(0, DEPTH-1)));
            uv   = ($urandom_range(0, 2) == 0);
            utgt = ($urandom_range(0, 1) == 0) ? PC_W'($urandom_range(0, 7) * 16'h0100)
                                               : PC_W'($urandom);
            uh   = m_hit(upc);
            upt  = m_tgt[upc[IDX_W-1:0]];
            if ($urandom_range(0, 7) == 0) begin uh = ~uh; upt = PC_W'($urandom); end
            step(pc, uv, upc, utgt, uh, upt, "R2 random lookup");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule